// File: doc/BRIEF.md
# Hotswap Pass-Switch Mode Controller

This block is the digital sequencer for the pass switch that connects a powered device's converter input to the negative supply rail. It watches two sampled measurements, the voltage drop across the pass switch and the port voltage, both in millivolts. It advances only on a clock-enable tick that arrives at a known rate. From these it selects one of four switch modes: open, inrush current limiting, fully enhanced, or low-current overload limiting. The analog current loops, comparators and the pass device itself sit outside the block and act on the mode code.

Port voltage passes through an undervoltage lockout with hysteresis. While lockout holds, the switch stays open. Once lockout releases and the detection/classification handshake has finished, the switch enters inrush limiting. When the drop shows the bulk capacitor is charged, the switch moves to fully on. A high drop that lasts a qualified number of ticks is treated as an overload. The block leaves overload only when the drop is low again and a minimum dwell has passed. Both durations are parameters counted in ticks.

Top module: `hs_switch_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, `mode` is OFF (code 0) and `lockout` is 1.
- R2: `mode` uses the codes OFF=0, INRUSH=1, ON=2, OVERLOAD=3. `mode` and `lockout` change only on the clock edge at which `tick` is 1.
- R3: On a tick, an engaged lockout releases when `port_mv` > RISE_MV (37000). A released lockout engages when `port_mv` < FALL_MV (32000). Values between the two thresholds, including each threshold itself, keep the current lockout state.
- R4: On the tick at which lockout is engaged or becomes engaged, `mode` goes to OFF on that same edge, from any state, and both timers restart from zero.
- R5: OFF moves only to INRUSH. It does so on a tick where lockout is released (or releases) and `class_done` is 1. Otherwise it stays OFF.
- R6: INRUSH moves to ON on a tick where `drop_mv` < 380. A drop of 380 or more keeps INRUSH.
- R7: ON moves to OVERLOAD on the QUAL_TICKS-th consecutive tick with `drop_mv` > 3600.
- R8: A tick in ON with `drop_mv` <= 3600 restarts the high-drop count, so a shorter run of high ticks never causes OVERLOAD.
- R9: OVERLOAD returns to ON only on a tick with `drop_mv` < 360 after at least DWELL_TICKS ticks have been spent in OVERLOAD. The earliest exit is therefore the tick numbered DWELL_TICKS+1 after entry.
- R10: No transition exists other than those in R4 to R9. In particular, ON and OVERLOAD never go back to INRUSH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable at the timer rate (one tick = one timer unit) |
| drop_mv | input | MV_W | Sampled voltage across the pass switch, mV |
| port_mv | input | MV_W | Sampled port voltage, mV |
| class_done | input | 1 | Detection and classification have completed |
| mode | output | 2 | Switch mode command (R2 encoding) |
| lockout | output | 1 | Undervoltage lockout engaged |

## Verification
The assertions assume that `tick` and both measurements are driven to known values from reset onward. They also assume the measurements are sampled only on tick edges, so any value held between ticks is ignored. The stimulus changes inputs only at falling clock edges and raises `tick` for a single cycle at irregular spacing. The drop and port voltages stick to their previous values most of the time, which produces runs long enough to reach the qualification and dwell limits. Directed steps hit each threshold value and the value one below or above it.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_OFF    = 2'd0,
    HS_INRUSH = 2'd1,
    HS_ON     = 2'd2,
    HS_OVLD   = 2'd3
  } hs_mode_e;
endpackage

// File: rtl/hs_uvlo.sv
module hs_uvlo #(
  parameter int          MV_W    = 16,
  parameter int unsigned RISE_MV = 37000,
  parameter int unsigned FALL_MV = 32000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [MV_W-1:0] port_mv,
  output logic            lock_q,
  output logic            lock_d
);
  localparam logic [MV_W-1:0] RISE_L = MV_W'(RISE_MV);
  localparam logic [MV_W-1:0] FALL_L = MV_W'(FALL_MV);

  always_comb begin
    lock_d = lock_q;
    if (tick) begin
      if (lock_q) lock_d = !(port_mv > RISE_L);
      else        lock_d = (port_mv < FALL_L);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else if (tick) lock_q <= lock_d;
  end

  // R3: a released lockout cannot re-engage while the port sits at or above the fall level
  a_r3_no_engage_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && tick && port_mv >= FALL_L) |=> !lock_q);
  a_r3_no_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && tick && port_mv <= RISE_L) |=> lock_q);
endmodule

// File: rtl/hs_tick_cnt.sv
module hs_tick_cnt #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) begin
      if (!run)            cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

  // R8: a tick without run always leaves the counter short of its limit
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !run && LIMIT > 0) |=> !done);
endmodule

// File: rtl/hs_switch_ctrl.sv
module hs_switch_ctrl
  import hs_pkg::*;
#(
  parameter int          MV_W        = 16,
  parameter int unsigned RISE_MV     = 37000,
  parameter int unsigned FALL_MV     = 32000,
  parameter int unsigned CHARGED_MV  = 380,
  parameter int unsigned OVL_HI_MV   = 3600,
  parameter int unsigned RECOVER_MV  = 360,
  parameter int unsigned QUAL_TICKS  = 140,
  parameter int unsigned DWELL_TICKS = 80000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [MV_W-1:0] drop_mv,
  input  logic [MV_W-1:0] port_mv,
  input  logic            class_done,
  output logic [1:0]      mode,
  output logic            lockout
);
  localparam logic [MV_W-1:0] CHG_L = MV_W'(CHARGED_MV);
  localparam logic [MV_W-1:0] HI_L  = MV_W'(OVL_HI_MV);
  localparam logic [MV_W-1:0] REC_L = MV_W'(RECOVER_MV);
  localparam int unsigned QUAL_LIM  = (QUAL_TICKS > 1) ? QUAL_TICKS - 1 : 0;

  hs_mode_e state_q, state_d;
  logic     lock_q, lock_d;
  logic     drop_hi, drop_rec, drop_chg;
  logic     qual_run, qual_done, dwell_run, dwell_done;

  assign drop_hi  = drop_mv > HI_L;
  assign drop_rec = drop_mv < REC_L;
  assign drop_chg = drop_mv < CHG_L;

  hs_uvlo #(.MV_W(MV_W), .RISE_MV(RISE_MV), .FALL_MV(FALL_MV)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .port_mv(port_mv),
    .lock_q(lock_q), .lock_d(lock_d)
  );

  assign qual_run  = (state_q == HS_ON) && drop_hi && !lock_d;
  assign dwell_run = (state_q == HS_OVLD) && !lock_d;

  hs_tick_cnt #(.LIMIT(QUAL_LIM)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(qual_run), .done(qual_done)
  );

  hs_tick_cnt #(.LIMIT(DWELL_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(dwell_run), .done(dwell_done)
  );

  always_comb begin
    state_d = state_q;
    if (lock_d) state_d = HS_OFF;
    else begin
      unique case (state_q)
        HS_OFF:    if (class_done)              state_d = HS_INRUSH;
        HS_INRUSH: if (drop_chg)                state_d = HS_ON;
        HS_ON:     if (drop_hi && qual_done)    state_d = HS_OVLD;
        HS_OVLD:   if (drop_rec && dwell_done)  state_d = HS_ON;
        default:                                state_d = HS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_OFF;
    else if (tick) state_q <= state_d;
  end

  assign mode    = state_q;
  assign lockout = lock_q;

  // R4: an engaged lockout always coincides with the open switch
  a_r4_lock_off: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (state_q == HS_OFF));
  // R2: nothing moves without a tick
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(state_q) && $stable(lock_q)));
  // R5: leaving OFF needs the classification handshake
  a_r5_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_OFF && !(tick && class_done)) |=> (state_q == HS_OFF));
  // R6: no move to ON while the capacitor is still charging
  a_r6_inrush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_INRUSH && tick && !drop_chg) |=> (state_q != HS_ON));
  // R7: overload is only declared on a high-drop tick
  a_r7_ovl_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_ON && !(tick && drop_hi)) |=> (state_q != HS_OVLD));
  // R9: recovery needs a low drop and an expired dwell
  a_r9_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_OVLD && !(tick && drop_rec && dwell_done)) |=> (state_q != HS_ON));
  // R10: a running switch never falls back to inrush
  a_r10_no_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_ON || state_q == HS_OVLD) |=> (state_q != HS_INRUSH));
endmodule

// File: tb/hs_switch_ctrl_tb.sv
`timescale 1ns/1ps
module hs_switch_ctrl_tb;
  localparam int QUAL  = 6;
  localparam int DWELL = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [15:0] drop_mv, port_mv;
  logic        class_done;
  logic [1:0]  mode;
  logic        lockout;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  // bench reference model state
  int m_state, m_q, m_d;
  bit m_lock;

  always #2 clk = ~clk;

  hs_switch_ctrl #(.QUAL_TICKS(QUAL), .DWELL_TICKS(DWELL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drop_mv(drop_mv),
    .port_mv(port_mv), .class_done(class_done), .mode(mode), .lockout(lockout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit next_lock(bit lk, int port);
    if (lk) return !(port > 37000);
    return port < 32000;
  endfunction

  task automatic model_tick(int drop, int port, bit cd);
    m_lock = next_lock(m_lock, port);
    if (m_lock) begin
      m_state = 0; m_q = 0; m_d = 0;
    end else begin
      case (m_state)
        0: if (cd) m_state = 1;
        1: if (drop < 380) m_state = 2;
        2: begin
          if (drop > 3600) begin
            m_q++;
            if (m_q >= QUAL) begin m_state = 3; m_q = 0; m_d = 0; end
          end else m_q = 0;
        end
        default: begin
          if (drop < 360 && m_d >= DWELL) begin m_state = 2; m_d = 0; end
          else m_d++;
        end
      endcase
    end
  endtask

  task automatic do_tick(int drop, int port, bit cd);
    @(negedge clk);
    drop_mv = 16'(drop); port_mv = 16'(port); class_done = cd; tick = 1'b1;
    model_tick(drop, port, cd);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_state(int st, bit lk, string tag);
    chk(int'(mode) == st, tag, int'(mode), st);
    chk(lockout == lk, tag, int'(lockout), int'(lk));
  endtask

  initial begin
    #(4.0 * 190000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int drop, port;
    bit cd;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; tick = 1'b0; drop_mv = 16'd0; port_mv = 16'd0; class_done = 1'b0;
    m_state = 0; m_q = 0; m_d = 0; m_lock = 1'b1;
    repeat (3) @(negedge clk);
    expect_state(0, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_state(0, 1'b1, "R1 after reset");

    do_tick(5000, 37000, 1'b1); expect_state(0, 1'b1, "R3 rise threshold holds lockout");
    do_tick(5000, 37001, 1'b0); expect_state(0, 1'b0, "R3 release above rise");
    do_tick(5000, 45000, 1'b0); expect_state(0, 1'b0, "R5 stays OFF without class_done");
    // R2: inputs change without tick, outputs hold
    @(negedge clk); class_done = 1'b1; drop_mv = 16'd0;
    repeat (3) @(negedge clk);
    expect_state(0, 1'b0, "R2 no change without tick");
    do_tick(5000, 45000, 1'b1); expect_state(1, 1'b0, "R5 OFF to INRUSH");
    do_tick(380, 45000, 1'b1);  expect_state(1, 1'b0, "R6 drop 380 keeps INRUSH");
    do_tick(379, 45000, 1'b1);  expect_state(2, 1'b0, "R6 drop 379 to ON");
    for (int i = 0; i < QUAL - 1; i++) do_tick(3601, 45000, 1'b1);
    expect_state(2, 1'b0, "R8 short excursion");
    do_tick(3600, 45000, 1'b1); expect_state(2, 1'b0, "R8 drop 3600 is not high");
    for (int i = 0; i < QUAL - 1; i++) do_tick(4000, 45000, 1'b1);
    expect_state(2, 1'b0, "R8 count restarted");
    do_tick(4000, 45000, 1'b1); expect_state(3, 1'b0, "R7 qualified overload");
    for (int i = 0; i < DWELL; i++) do_tick(100, 45000, 1'b1);
    expect_state(3, 1'b0, "R9 dwell not yet expired");
    do_tick(360, 45000, 1'b1); expect_state(3, 1'b0, "R9 drop 360 keeps OVERLOAD");
    do_tick(359, 45000, 1'b1); expect_state(2, 1'b0, "R9 recovery to ON");
    do_tick(100, 32000, 1'b1); expect_state(2, 1'b0, "R3 fall threshold keeps release");
    do_tick(100, 31999, 1'b1); expect_state(0, 1'b1, "R4 lockout forces OFF");
    // R4: qualification count cleared by lockout
    do_tick(5000, 45000, 1'b1); expect_state(1, 1'b0, "R5 release and enter INRUSH");
    do_tick(100, 45000, 1'b1);  expect_state(2, 1'b0, "R6 back to ON");
    for (int i = 0; i < 3; i++) do_tick(4000, 45000, 1'b1);
    do_tick(4000, 20000, 1'b1); expect_state(0, 1'b1, "R4 lockout from ON");
    do_tick(5000, 45000, 1'b1);
    do_tick(100, 45000, 1'b1);
    for (int i = 0; i < QUAL - 1; i++) do_tick(4000, 45000, 1'b1);
    expect_state(2, 1'b0, "R4 timer cleared by lockout");
    do_tick(4000, 45000, 1'b1); expect_state(3, 1'b0, "R7 overload after full count");
    do_tick(4000, 10000, 1'b1); expect_state(0, 1'b1, "R4 lockout from OVERLOAD");

    // random phase against the bench model
    drop = 100; port = 45000; cd = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 20) begin
        case ($urandom_range(3))
          0: drop = $urandom_range(359);
          1: drop = 360 + $urandom_range(19);
          2: drop = 380 + $urandom_range(3220);
          default: drop = 3601 + $urandom_range(1400);
        endcase
      end
      if ($urandom_range(99) < 3) begin
        case ($urandom_range(2))
          0: port = 20000 + $urandom_range(11999);
          1: port = 32000 + $urandom_range(5000);
          default: port = 37001 + $urandom_range(19000);
        endcase
      end
      cd = ($urandom_range(9) < 8);
      do_tick(drop, port, cd);
      chk(int'(mode) == m_state, "R10 random mode vs model", int'(mode), m_state);
      chk(lockout == m_lock, "R3 random lockout vs model", int'(lockout), int'(m_lock));
      repeat ($urandom_range(2)) @(negedge clk);
      chk(int'(mode) == m_state, "R2 random hold between ticks", int'(mode), m_state);
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule